// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This block performs the four single-bit operations of a processor datapath: test a bit, toggle it, clear it or set it. The operand is already fetched. It is either a 32-bit data register or a single memory byte. The bit number comes from a register or from an immediate field, and the caller states which. The block reduces the bit number to the operand width and builds a one-hot mask. It then computes the updated Z flag from the bit's value before any change, and forms the modified operand.

One registered stage sits between the request and the result. A request presented with `valid_i` high produces one result cycle with `valid_o` high. That result carries the value to write back, a write strobe, the full condition-flag vector and the base cycle count of the operation. The caller also flags an address-register-direct destination. Such a request is refused: the illegal output is raised and nothing is written.

Top module: `bitop_unit`

## Requirements
- R1: A request accepted with `valid_i` high at a rising clock edge appears at the outputs in the next cycle with `valid_o` high. After reset, `valid_o`, `wr_en_o`, `illegal_o`, `result_o`, `flags_o` and `cycles_o` are all zero.
- R2: The operation code `op_i` is 0 for test, 1 for toggle, 2 for clear and 3 for set. With `is_reg_i`=1 the operand is 32 bits wide and the bit index is `bit_num_i` modulo 32.
- R3: With `is_reg_i`=0 the operand is byte `operand_i[7:0]` and the bit index is `bit_num_i` modulo 8. `result_o[31:8]` is zero for a legal request.
- R4: `flags_o[2]` (Z) is 1 when the selected bit of the operand was 0 before modification, and 0 when it was 1.
- R5: A test operation never asserts `wr_en_o`. Its `result_o` equals the width-reduced operand.
- R6: Toggle, clear and set assert `wr_en_o` and return the operand XOR mask, operand AND NOT mask, and operand OR mask respectively.
- R7: Flag vector layout is {X,N,Z,V,C} = bits 4..0. X, N, V and C in `flags_o` equal those of `flags_i` from the request.
- R8: With `imm_form_i`=0 (bit number from a register), `cycles_o` is 8 for toggle and set. It is 4 for test and 8 for clear, with 2 added to either of these when `is_reg_i`=1.
- R9: With `imm_form_i`=1, `cycles_o` is 12 for toggle and set. It is 8 for test and 12 for clear, with 2 added to either of these when `is_reg_i`=1.
- R10: A request with `addr_reg_i`=1 sets `illegal_o`, keeps `wr_en_o` low, returns `flags_o` equal to `flags_i`, returns `result_o` equal to `operand_i`, and gives `cycles_o` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation: 0 test, 1 toggle, 2 clear, 3 set |
| imm_form_i | input | 1 | Bit number taken from an immediate field |
| is_reg_i | input | 1 | Operand is a 32-bit data register (else a memory byte) |
| addr_reg_i | input | 1 | Destination is address-register direct (refused) |
| bit_num_i | input | BN_W | Raw bit number |
| operand_i | input | DATA_W | Operand value |
| flags_i | input | 5 | Current flags {X,N,Z,V,C} |
| valid_o | output | 1 | Result strobe |
| result_o | output | DATA_W | Value to write back |
| wr_en_o | output | 1 | Write-back enable |
| flags_o | output | 5 | Updated flags {X,N,Z,V,C} |
| cycles_o | output | CYC_W | Base cycle count |
| illegal_o | output | 1 | Request refused |

## Verification
Some properties are checked on every cycle:
- the one-cycle latency of the strobe;
- that the write strobe never accompanies a refused request;
- that X, N, V and C pass through;
- that byte results keep their upper bits clear;
- that the cycle count of a legal result is one of the permitted values.

Other behaviour can only be shown by the scoreboard scenarios:
- index wrap at 32 and at 8;
- Z tracking the pre-modification bit value;
- the exact toggle, clear and set results;
- the exact cycle count for each operation, form and operand kind.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    BOP_TEST = 2'd0,
    BOP_FLIP = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_SET  = 2'd3
  } bop_e;

  localparam int FLG_W = 5;
  localparam int FLG_X = 4;
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;
endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int BN_W   = 8
) (
  input  logic [BN_W-1:0]   bit_num_i,
  input  logic              is_reg_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam int REG_IW = $clog2(DATA_W);
  localparam int MEM_IW = $clog2(BYTE_W);

  logic [REG_IW-1:0] idx;

  always_comb begin
    if (is_reg_i) idx = bit_num_i[REG_IW-1:0];
    else          idx = REG_IW'(bit_num_i[MEM_IW-1:0]);
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask_o[i] = (idx == REG_IW'(i));
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  bop_e              op_i,
  input  logic              is_reg_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] result_o,
  output logic              z_o
);
  localparam logic [DATA_W-1:0] BYTE_KEEP = DATA_W'({BYTE_W{1'b1}});

  logic [DATA_W-1:0] opnd;

  assign opnd = is_reg_i ? operand_i : (operand_i & BYTE_KEEP);
  assign z_o  = ~|(opnd & mask_i);

  always_comb begin
    unique case (op_i)
      BOP_FLIP: result_o = opnd ^ mask_i;
      BOP_CLR:  result_o = opnd & ~mask_i;
      BOP_SET:  result_o = opnd | mask_i;
      default:  result_o = opnd;
    endcase
  end
endmodule

// File: rtl/bitop_cycles.sv
module bitop_cycles
  import bitop_pkg::*;
#(
  parameter int CYC_W = 5
) (
  input  bop_e             op_i,
  input  logic             imm_form_i,
  input  logic             is_reg_i,
  output logic [CYC_W-1:0] cycles_o
);
  localparam logic [CYC_W-1:0] IMM_EXTRA = CYC_W'(4);
  localparam logic [CYC_W-1:0] REG_EXTRA = CYC_W'(2);

  logic [CYC_W-1:0] base;
  logic             widen;

  always_comb begin
    unique case (op_i)
      BOP_TEST: base = CYC_W'(4);
      default:  base = CYC_W'(8);
    endcase
    // only test and clear pay the register surcharge
    widen    = is_reg_i && (op_i == BOP_TEST || op_i == BOP_CLR);
    cycles_o = base + (imm_form_i ? IMM_EXTRA : '0) + (widen ? REG_EXTRA : '0);
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int BN_W   = 8,
  parameter int CYC_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              imm_form_i,
  input  logic              is_reg_i,
  input  logic              addr_reg_i,
  input  logic [BN_W-1:0]   bit_num_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [4:0]        flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [4:0]        flags_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              illegal_o
);
  bop_e              op;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] alu_res;
  logic              alu_z;
  logic [CYC_W-1:0]  cyc;
  logic [4:0]        flags_nxt;

  assign op = bop_e'(op_i);

  bitop_mask #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .BN_W(BN_W)) u_mask (
    .bit_num_i (bit_num_i),
    .is_reg_i  (is_reg_i),
    .mask_o    (mask)
  );

  bitop_alu #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_alu (
    .op_i      (op),
    .is_reg_i  (is_reg_i),
    .operand_i (operand_i),
    .mask_i    (mask),
    .result_o  (alu_res),
    .z_o       (alu_z)
  );

  bitop_cycles #(.CYC_W(CYC_W)) u_cyc (
    .op_i       (op),
    .imm_form_i (imm_form_i),
    .is_reg_i   (is_reg_i),
    .cycles_o   (cyc)
  );

  always_comb begin
    flags_nxt = flags_i;
    if (!addr_reg_i) flags_nxt[FLG_Z] = alu_z;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      flags_o   <= '0;
      cycles_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      wr_en_o   <= valid_i && !addr_reg_i && (op != BOP_TEST);
      illegal_o <= valid_i && addr_reg_i;
      if (valid_i) begin
        result_o <= addr_reg_i ? operand_i : alu_res;
        flags_o  <= flags_nxt;
        cycles_o <= addr_reg_i ? '0 : cyc;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int BN_W   = 8,
  parameter int CYC_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              is_reg_i,
  input logic              addr_reg_i,
  input logic [4:0]        flags_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [4:0]        flags_o,
  input logic [CYC_W-1:0]  cycles_o,
  input logic              illegal_o
);
  assert_valid_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_byte_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o && !$past(is_reg_i)) |-> (result_o[DATA_W-1:BYTE_W] == '0));

  assert_wr_needs_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (valid_o && !illegal_o));

  assert_flags_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (flags_o[4:3] == $past(flags_i[4:3]) && flags_o[1:0] == $past(flags_i[1:0])));

  assert_cycles_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o) |-> (cycles_o inside {CYC_W'(4), CYC_W'(6), CYC_W'(8),
                                                  CYC_W'(10), CYC_W'(12), CYC_W'(14)}));

  assert_illegal_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($past(valid_i) && $past(addr_reg_i) && !wr_en_o && flags_o == $past(flags_i)));
endmodule

bind bitop_unit bitop_unit_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .BN_W(BN_W), .CYC_W(CYC_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .is_reg_i   (is_reg_i),
  .addr_reg_i (addr_reg_i),
  .flags_i    (flags_i),
  .valid_o    (valid_o),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .flags_o    (flags_o),
  .cycles_o   (cycles_o),
  .illegal_o  (illegal_o)
);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  localparam int DATA_W = 32;
  localparam int BN_W   = 8;
  localparam int CYC_W  = 5;

  typedef struct {
    logic [DATA_W-1:0] result;
    logic              wr;
    logic [4:0]        flags;
    logic [CYC_W-1:0]  cycles;
    logic              illegal;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0;
  logic [1:0]        op_i = '0;
  logic              imm_form_i = 1'b0;
  logic              is_reg_i = 1'b0;
  logic              addr_reg_i = 1'b0;
  logic [BN_W-1:0]   bit_num_i = '0;
  logic [DATA_W-1:0] operand_i = '0;
  logic [4:0]        flags_i = '0;
  logic              valid_o;
  logic [DATA_W-1:0] result_o;
  logic              wr_en_o;
  logic [4:0]        flags_o;
  logic [CYC_W-1:0]  cycles_o;
  logic              illegal_o;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitop_unit #(.DATA_W(DATA_W), .BN_W(BN_W), .CYC_W(CYC_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .imm_form_i(imm_form_i), .is_reg_i(is_reg_i), .addr_reg_i(addr_reg_i),
    .bit_num_i(bit_num_i), .operand_i(operand_i), .flags_i(flags_i),
    .valid_o(valid_o), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_o(flags_o), .cycles_o(cycles_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected model built from the requirements
  function automatic exp_t model(input logic [1:0] op, input logic imm, input logic isreg,
                                 input logic areg, input logic [BN_W-1:0] bn,
                                 input logic [DATA_W-1:0] opnd_raw, input logic [4:0] fl,
                                 input string tag);
    exp_t e;
    int idx;
    logic [DATA_W-1:0] opnd, m;
    e.tag = tag;
    if (areg) begin
      e.result = opnd_raw; e.wr = 1'b0; e.flags = fl; e.cycles = '0; e.illegal = 1'b1;
      return e;
    end
    idx  = isreg ? int'(bn) % 32 : int'(bn) % 8;
    opnd = isreg ? opnd_raw : {24'h0, opnd_raw[7:0]};
    m    = 32'h1 << idx;
    e.flags = fl;
    e.flags[2] = (opnd[idx] == 1'b0);
    case (op)
      2'd1: e.result = opnd ^ m;
      2'd2: e.result = opnd & ~m;
      2'd3: e.result = opnd | m;
      default: e.result = opnd;
    endcase
    e.wr = (op != 2'd0);
    if (op == 2'd1 || op == 2'd3) e.cycles = 5'd8;
    else e.cycles = ((op == 2'd0) ? 5'd4 : 5'd8) + (isreg ? 5'd2 : 5'd0);
    if (imm) e.cycles = e.cycles + 5'd4;
    e.illegal = 1'b0;
    return e;
  endfunction

  task automatic drive(input logic [1:0] op, input logic imm, input logic isreg,
                       input logic areg, input logic [BN_W-1:0] bn,
                       input logic [DATA_W-1:0] opnd, input logic [4:0] fl, input string tag);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; imm_form_i = imm; is_reg_i = isreg; addr_reg_i = areg;
    bit_num_i = bn; operand_i = opnd; flags_i = fl;
    sb.push_back(model(op, imm, isreg, areg, bn, opnd, fl, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid_o) begin
        if (sb.size() == 0) begin
          chk("R1 unexpected result", 64'(valid_o), 64'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " result"},  64'(result_o),  64'(e.result));
          chk({e.tag, " wr_en"},   64'(wr_en_o),   64'(e.wr));
          chk({e.tag, " flags"},   64'(flags_o),   64'(e.flags));
          chk({e.tag, " cycles"},  64'(cycles_o),  64'(e.cycles));
          chk({e.tag, " illegal"}, 64'(illegal_o), 64'(e.illegal));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", 64'(valid_o), 64'(0));
    chk("R1 reset wr", 64'(wr_en_o), 64'(0));
    chk("R1 reset result", 64'(result_o), 64'(0));
    chk("R1 reset flags/cycles", 64'({flags_o, cycles_o, illegal_o}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 R5 test on register, bit 31 set -> Z=0
    drive(2'd0, 1'b0, 1'b1, 1'b0, 8'd31, 32'h8000_0000, 5'b10101, "R2 R4 R5 test reg");
    // R2 wrap mod 32 (45 -> 13), toggle, R6 R8
    drive(2'd1, 1'b0, 1'b1, 1'b0, 8'd45, 32'h0000_0000, 5'b01010, "R2 R6 R8 flip reg wrap");
    // R3 wrap mod 8 (45 -> 5), clear on byte, upper bits dropped
    drive(2'd2, 1'b0, 1'b0, 1'b0, 8'd45, 32'hABCD_EF20, 5'b11111, "R3 R6 R8 clr mem wrap");
    // R6 set on register, immediate form R9
    drive(2'd3, 1'b1, 1'b1, 1'b0, 8'd0, 32'h1234_5670, 5'b00000, "R6 R9 set reg imm");
    // R9 test immediate on memory, R4 Z=1
    drive(2'd0, 1'b1, 1'b0, 1'b0, 8'd7, 32'hFFFF_FF7F, 5'b11011, "R4 R5 R9 test mem imm");
    idle();
    // R9 clear immediate register, bit already set
    drive(2'd2, 1'b1, 1'b1, 1'b0, 8'd64, 32'hFFFF_FFFF, 5'b00100, "R6 R9 clr reg imm");
    // R8 test register form on register
    drive(2'd0, 1'b0, 1'b1, 1'b0, 8'd3, 32'h0000_0008, 5'b00000, "R8 test reg");
    // R8 set register form on memory, R7 flags kept
    drive(2'd3, 1'b0, 1'b0, 1'b0, 8'd255, 32'h0000_0001, 5'b11011, "R7 R8 set mem");
    // R9 flip immediate on memory
    drive(2'd1, 1'b1, 1'b0, 1'b0, 8'd8, 32'hFFFF_FF01, 5'b00100, "R3 R9 flip mem imm");
    // R10 refused destination
    drive(2'd3, 1'b0, 1'b1, 1'b1, 8'd4, 32'hDEAD_BEEF, 5'b10110, "R10 addr reg");
    idle();
    idle();
    // R1 no result when idle
    chk("R1 idle valid", 64'(valid_o), 64'(0));
    chk("R5 idle wr", 64'(wr_en_o), 64'(0));
    chk("R1 scoreboard drained", 64'(sb.size()), 64'(0));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule